// File: doc/BRIEF.md
# Indexed Color Palette with Auto-Advancing Host Port

This block is a 256-entry color lookup table placed in a display pixel stream. Each entry holds a 24-bit color with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. In 8-bit indexed mode every incoming pixel byte selects one entry, and that entry's color leaves the block one clock later. At 16 or 24/32 bits per pixel the table can be skipped with a bypass control. A 5-6-5 pixel is then widened to 8-8-8. A 24/32-bit pixel passes through as it came in.

Software reaches the table through two registers: an index and a data port. Writing the index selects an entry. Each following data read or data write touches the selected entry and moves the index on by one. After a single index write of zero, the whole table can therefore be streamed in or out with back-to-back data accesses. The table has two ports. Host accesses and pixel lookups go on in the same cycle without stalling each other.

Top module: `color_palette`

## Requirements
- R1: A table entry holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. A lookup returns those 24 bits unchanged on `pix_o`.
- R2: An index write (`idx_we_i`) loads `idx_wdata_i` into the index, visible on `idx_o` after the next clock edge. The next data access then targets that entry.
- R3: After each accepted data read or data write the index goes up by one, and it wraps from 255 to 0. With no access the index holds.
- R4: A data read (`dat_re_i`) returns the entry at the current index on `dat_rdata_o` one clock later. The value stays there until the next accepted read.
- R5: When an index write coincides with a data read or data write, only the index write takes effect. The table is not changed, `dat_rdata_o` is not updated, and the index takes the written value.
- R6: When a data write and a data read coincide without an index write, only the write is performed. `dat_rdata_o` keeps its value and the index advances once.
- R7: In mode 0 (8 bpp), `pix_o` equals the entry selected by `pix_i[7:0]`, one clock after the input. This holds whatever the bypass bit is set to.
- R8: In mode 1 (16 bpp, 5-6-5 in `pix_i[15:0]`) with bypass set, each component is widened to 8 bits by copying its top bits into its low bits.
- R9: In mode 2 or 3 (24/32 bpp) with bypass set, `pix_o` equals `pix_i[23:0]` one clock later.
- R10: In mode 1, 2 or 3 with bypass clear, `pix_o` is the table entry selected by `pix_i[7:0]`.
- R11: `pix_valid_o`, `hsync_o`, `vsync_o` and `blank_o` repeat their inputs exactly one clock later, aligned with `pix_o`.
- R12: A host data write and a pixel lookup of the same entry in one cycle are both served. The lookup returns the old contents, and a lookup in the next cycle returns the new contents.
- R13: While reset is applied and after it is released, `idx_o`, `dat_rdata_o`, `pix_o` and the delayed sideband outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Write strobe for the index register |
| idx_wdata_i | input | 8 | New index value |
| dat_we_i | input | 1 | Data port write strobe |
| dat_re_i | input | 1 | Data port read strobe |
| dat_wdata_i | input | 24 | Color written to the selected entry |
| dat_rdata_o | output | 24 | Color read from the data port |
| idx_o | output | 8 | Current index |
| mode_i | input | 2 | Pixel depth: 0 = 8, 1 = 16, 2/3 = 24/32 bpp |
| bypass_i | input | 1 | Skip the table at depths above 8 bpp |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 24 | Input pixel |
| hsync_i | input | 1 | Horizontal sync travelling with the pixel |
| vsync_i | input | 1 | Vertical sync travelling with the pixel |
| blank_i | input | 1 | Blanking travelling with the pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Output color |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| blank_o | output | 1 | Delayed blanking |

## Verification
A host data write and a pixel lookup can fall in the same cycle and address the same entry. The bench provokes this by driving a write to entry k on the same clock edge as an 8 bpp pixel of value k. The first output must carry the pre-write color. A repeat of the pixel on the next cycle must show the newly written color. Coinciding host strobes (index write with data access, and write with read) are also driven together, and the results are judged by reading the table back through the data port.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_16 = 2'd1,
    DEPTH_24 = 2'd2,
    DEPTH_32 = 2'd3
  } depth_e;

  localparam int SB_W = 4;  // valid, hsync, vsync, blank
endpackage

// File: rtl/pal_host_port.sv
module pal_host_port #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic [IDX_W-1:0] idx_wdata_i,
  input  logic             dat_we_i,
  input  logic             dat_re_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             mem_we_o,
  output logic             mem_re_o
);
  logic [IDX_W-1:0] idx_q;
  logic             step;

  // index write dominates; write dominates read
  assign mem_we_o = dat_we_i & ~idx_we_i;
  assign mem_re_o = dat_re_i & ~dat_we_i & ~idx_we_i;
  assign step     = (dat_we_i | dat_re_i) & ~idx_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= idx_wdata_i;
    else if (step)     idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [IDX_W-1:0] pix_addr_i,
  output logic [DW-1:0]    pix_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[host_addr_i] <= wdata_i;
  end

  // both reads see contents before any same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      pix_data_o <= '0;
    end else begin
      if (re_i) rdata_o <= mem[host_addr_i];
      pix_data_o <= mem[pix_addr_i];
    end
  end
endmodule

// File: rtl/pal_pix_path.sv
module pal_pix_path
  import pal_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              bypass_i,
  input  logic [3*CW-1:0]   pix_i,
  input  logic [SB_W-1:0]   sb_i,
  input  logic [3*CW-1:0]   lut_i,
  output logic [3*CW-1:0]   pix_o,
  output logic [SB_W-1:0]   sb_o
);
  localparam int PW = 3 * CW;

  depth_e          depth;
  logic            skip;
  logic [PW-1:0]   byp_d, byp_q;
  logic            skip_q;
  logic [4:0]      r5, b5;
  logic [5:0]      g6;

  assign depth = depth_e'(mode_i);
  assign skip  = bypass_i & (depth != DEPTH_8);
  assign r5    = pix_i[15:11];
  assign g6    = pix_i[10:5];
  assign b5    = pix_i[4:0];

  always_comb begin
    if (depth == DEPTH_16)
      byp_d = {r5, r5[4 -: (CW-5)], g6, g6[5 -: (CW-6)], b5, b5[4 -: (CW-5)]};
    else
      byp_d = pix_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= '0;
      skip_q <= 1'b0;
      sb_o   <= '0;
    end else begin
      byp_q  <= byp_d;
      skip_q <= skip;
      sb_o   <= sb_i;
    end
  end

  assign pix_o = skip_q ? byp_q : lut_i;
endmodule

// File: rtl/color_palette.sv
module color_palette
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [3*CW-1:0]   dat_wdata_i,
  output logic [3*CW-1:0]   dat_rdata_o,
  output logic [IDX_W-1:0]  idx_o,
  input  logic [1:0]        mode_i,
  input  logic              bypass_i,
  input  logic              pix_valid_i,
  input  logic [3*CW-1:0]   pix_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              blank_i,
  output logic              pix_valid_o,
  output logic [3*CW-1:0]   pix_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o
);
  localparam int PW = 3 * CW;

  logic            mem_we, mem_re;
  logic [PW-1:0]   lut_data;
  logic [SB_W-1:0] sb_in, sb_out;

  pal_host_port #(.IDX_W(IDX_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_we_i    (idx_we_i),
    .idx_wdata_i (idx_wdata_i),
    .dat_we_i    (dat_we_i),
    .dat_re_i    (dat_re_i),
    .idx_o       (idx_o),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re)
  );

  pal_ram #(.IDX_W(IDX_W), .DW(PW)) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (mem_we),
    .re_i        (mem_re),
    .host_addr_i (idx_o),
    .wdata_i     (dat_wdata_i),
    .rdata_o     (dat_rdata_o),
    .pix_addr_i  (pix_i[IDX_W-1:0]),
    .pix_data_o  (lut_data)
  );

  assign sb_in = {pix_valid_i, hsync_i, vsync_i, blank_i};

  pal_pix_path #(.CW(CW)) u_pix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .bypass_i (bypass_i),
    .pix_i    (pix_i),
    .sb_i     (sb_in),
    .lut_i    (lut_data),
    .pix_o    (pix_o),
    .sb_o     (sb_out)
  );

  assign {pix_valid_o, hsync_o, vsync_o, blank_o} = sb_out;
endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idx_we_i,
  input logic [IDX_W-1:0]  idx_wdata_i,
  input logic              dat_we_i,
  input logic              dat_re_i,
  input logic [3*CW-1:0]   dat_rdata_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic [1:0]        mode_i,
  input logic              bypass_i,
  input logic              pix_valid_i,
  input logic [3*CW-1:0]   pix_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic              blank_i,
  input logic              pix_valid_o,
  input logic [3*CW-1:0]   pix_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              blank_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_idx_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    idx_we_i |=> idx_o == $past(idx_wdata_i));

  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (!idx_we_i && (dat_we_i || dat_re_i)) |=> idx_o == IDX_W'($past(idx_o) + 1'b1));

  assert_idx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (!idx_we_i && !dat_we_i && !dat_re_i) |=> $stable(idx_o));

  // covers the R5 and R6 masking of reads as well
  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !(dat_re_i && !dat_we_i && !idx_we_i) |=> $stable(dat_rdata_o));

  assert_sideband_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    1'b1 |=> {pix_valid_o, hsync_o, vsync_o, blank_o}
             == $past({pix_valid_i, hsync_i, vsync_i, blank_i}));

  assert_pass24_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (bypass_i && mode_i[1]) |=> pix_o == $past(pix_i));
endmodule

bind color_palette pal_checker #(.IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idx_we_i    (idx_we_i),
  .idx_wdata_i (idx_wdata_i),
  .dat_we_i    (dat_we_i),
  .dat_re_i    (dat_re_i),
  .dat_rdata_o (dat_rdata_o),
  .idx_o       (idx_o),
  .mode_i      (mode_i),
  .bypass_i    (bypass_i),
  .pix_valid_i (pix_valid_i),
  .pix_i       (pix_i),
  .hsync_i     (hsync_i),
  .vsync_i     (vsync_i),
  .blank_i     (blank_i),
  .pix_valid_o (pix_valid_o),
  .pix_o       (pix_o),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .blank_o     (blank_o)
);

// File: tb/color_palette_tb.sv
`timescale 1ns/1ps
module color_palette_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0]  idx_wdata = 0;
  logic [23:0] dat_wdata = 0;
  logic [23:0] dat_rdata;
  logic [7:0]  idx;
  logic [1:0]  mode = 0;
  logic        bypass = 0, pv = 0, hs = 0, vs = 0, bl = 0;
  logic [23:0] pix = 0;
  logic        pv_o, hs_o, vs_o, bl_o;
  logic [23:0] pix_out;

  int errors = 0;
  int checks = 0;
  logic [23:0] exp_mem [256];
  logic [7:0]  exp_idx = 0;

  always #4 clk = ~clk;

  color_palette u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .idx_we_i(idx_we), .idx_wdata_i(idx_wdata),
    .dat_we_i(dat_we), .dat_re_i(dat_re),
    .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata), .idx_o(idx),
    .mode_i(mode), .bypass_i(bypass), .pix_valid_i(pv), .pix_i(pix),
    .hsync_i(hs), .vsync_i(vs), .blank_i(bl),
    .pix_valid_o(pv_o), .pix_o(pix_out),
    .hsync_o(hs_o), .vsync_o(vs_o), .blank_o(bl_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_pix(input logic [1:0] m, input logic b, input logic [23:0] p);
    if (b && m != 2'd0) begin
      if (m == 2'd1)
        return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
      return p;
    end
    return exp_mem[p[7:0]];
  endfunction

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk);
    idx_we = 1; idx_wdata = v;
    @(negedge clk);
    idx_we = 0;
    exp_idx = v;
  endtask

  task automatic rd_one(input string req);
    logic [23:0] e;
    @(negedge clk);
    dat_re = 1;
    e = exp_mem[exp_idx];
    exp_idx = exp_idx + 1;
    @(negedge clk);
    dat_re = 0;
    chk(dat_rdata == e, req, dat_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] prev_exp, old, r0, nv;
    logic [3:0]  prev_sb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(idx == 0, "R13 idx", idx, 0);
    chk(dat_rdata == 0 && pix_out == 0, "R13 data", {dat_rdata ^ pix_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({pv_o, hs_o, vs_o, bl_o} == 0 && idx == 0, "R13 after release", {pv_o, hs_o, vs_o, bl_o}, 0);

    // R2/R3 stream-load all entries back to back
    set_idx(8'd0);
    for (int i = 0; i < 256; i++) begin
      dat_we = 1;
      dat_wdata = $urandom();
      exp_mem[exp_idx] = dat_wdata;
      exp_idx = exp_idx + 1;
      @(negedge clk);
    end
    dat_we = 0;
    chk(idx == 8'd0, "R3 wrap after 256 writes", idx, 0);

    // R4 stream-read back to back
    set_idx(8'd0);
    for (int i = 0; i < 256; i++) begin
      dat_re = 1;
      @(negedge clk);
      chk(dat_rdata == exp_mem[i], "R4 stream read", dat_rdata, exp_mem[i]);
    end
    dat_re = 0;
    repeat (3) @(negedge clk);
    chk(dat_rdata == exp_mem[255], "R4 read data holds", dat_rdata, exp_mem[255]);
    chk(idx == 8'd0, "R3 wrap after 256 reads", idx, 0);

    // R2/R3 wrap via explicit index
    set_idx(8'd253);
    chk(idx == 8'd253, "R2 index load", idx, 253);
    for (int i = 0; i < 5; i++) rd_one("R3 read across wrap");
    chk(idx == 8'd2, "R3 index after wrap", idx, 2);

    // R5 index write with data write
    set_idx(8'd10);
    @(negedge clk);
    idx_we = 1; idx_wdata = 8'd40; dat_we = 1; dat_wdata = 24'h123456;
    @(negedge clk);
    idx_we = 0; dat_we = 0;
    chk(idx == 8'd40, "R5 index wins over write", idx, 40);
    set_idx(8'd10);
    rd_one("R5 entry 10 untouched");
    set_idx(8'd40);
    rd_one("R5 entry 40 untouched");
    // R5 index write with data read
    r0 = dat_rdata;
    @(negedge clk);
    idx_we = 1; idx_wdata = 8'd3; dat_re = 1;
    @(negedge clk);
    idx_we = 0; dat_re = 0;
    chk(dat_rdata == r0, "R5 read masked", dat_rdata, r0);
    chk(idx == 8'd3, "R5 index after masked read", idx, 3);

    // R6 write and read together
    set_idx(8'd20);
    r0 = dat_rdata;
    @(negedge clk);
    dat_we = 1; dat_re = 1; dat_wdata = 24'hA5C3E1;
    @(negedge clk);
    dat_we = 0; dat_re = 0;
    exp_mem[20] = 24'hA5C3E1;
    chk(idx == 8'd21, "R6 single advance", idx, 21);
    chk(dat_rdata == r0, "R6 read ignored", dat_rdata, r0);
    set_idx(8'd20);
    rd_one("R6 write taken");

    // R1 field placement through a lookup
    set_idx(8'd77);
    @(negedge clk);
    dat_we = 1; dat_wdata = 24'hFF0080;
    @(negedge clk);
    dat_we = 0;
    exp_mem[77] = 24'hFF0080;
    mode = 2'd0; bypass = 0; pv = 1; pix = 24'd77;
    @(negedge clk);
    chk(pix_out == 24'hFF0080, "R1 red/green/blue layout", pix_out, 24'hFF0080);

    // R8 directed extremes
    mode = 2'd1; bypass = 1; pix = 24'h00FFFF;
    @(negedge clk);
    chk(pix_out == 24'hFFFFFF, "R8 565 all ones", pix_out, 24'hFFFFFF);
    pix = 24'h00F800;
    @(negedge clk);
    chk(pix_out == 24'hFF0000, "R8 565 red only", pix_out, 24'hFF0000);
    // R7 bypass ignored in 8bpp
    mode = 2'd0; bypass = 1; pix = 24'hABCD4D;
    @(negedge clk);
    chk(pix_out == exp_mem[8'h4D], "R7 bypass ignored at 8bpp", pix_out, exp_mem[8'h4D]);
    // R10 lookup at 24bpp without bypass
    mode = 2'd2; bypass = 0; pix = 24'h123499;
    @(negedge clk);
    chk(pix_out == exp_mem[8'h99], "R10 lookup at 24bpp", pix_out, exp_mem[8'h99]);

    // R7-R11 random pixel stream
    prev_exp = 0; prev_sb = 0;
    for (int i = 0; i < 400; i++) begin
      if (i > 0) begin
        chk(pix_out == prev_exp, "R7/R8/R9/R10 random pixel", pix_out, prev_exp);
        chk({pv_o, hs_o, vs_o, bl_o} == prev_sb, "R11 sideband delay", {pv_o, hs_o, vs_o, bl_o}, prev_sb);
      end
      mode = 2'($urandom_range(0, 3));
      bypass = 1'($urandom_range(0, 1));
      pix = $urandom();
      {pv, hs, vs, bl} = 4'($urandom());
      prev_exp = exp_pix(mode, bypass, pix);
      prev_sb = {pv, hs, vs, bl};
      @(negedge clk);
    end
    chk(pix_out == prev_exp, "R7/R8/R9/R10 last pixel", pix_out, prev_exp);

    // R12 host write and lookup of same entry in one cycle
    set_idx(8'd7);
    old = exp_mem[7];
    nv = ~old;
    @(negedge clk);
    dat_we = 1; dat_wdata = nv;
    mode = 2'd0; bypass = 0; pv = 1; pix = 24'd7;
    @(negedge clk);
    dat_we = 0;
    exp_mem[7] = nv;
    chk(pix_out == old, "R12 lookup sees old entry", pix_out, old);
    @(negedge clk);
    chk(pix_out == nv, "R12 next lookup sees new entry", pix_out, nv);
    chk(idx == 8'd8, "R12 host access still advanced", idx, 8);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule